// File: doc/BRIEF.md
# LCD Annunciator Backplane and Frontplane Generator

This block drives the static icon segments of a character or graphic LCD. It divides the display timing clock to make a backplane square wave with 50% duty. Each of several standalone annunciator frontplanes is derived from that backplane. A lit annunciator is driven in antiphase to the backplane, so its segment sees a net AC voltage. An unlit annunciator is driven in phase, so its segment sees none. When no annunciator is lit, all frontplanes rest at 0.

The host lights or clears one annunciator at a time by writing a one-byte control command. A master oscillator-enable input gates the whole waveform. While that input is low, every output is low and the divider is held cleared, so each enable starts from a known phase.

All outputs are logic-level signals; level shifting and the panel bias lie outside this block.

Top module: `lcd_ann_wave`

## Requirements
- R1: While reset is asserted and after it is released, every annunciator is off and `bp_o` and all of `ann_o` are 0 until the oscillator is enabled.
- R2: With `osc_en_i` high, `bp_o` has a period of `CLK_DIV` clocks and 50% duty. After the rising clock edges that sample `osc_en_i` high, `bp_o` is 0 for the first `CLK_DIV/2` of them and then 1 for the next `CLK_DIV/2`, repeating.
- R3: With the oscillator enabled and at least one annunciator on, every annunciator that is on drives `ann_o[i] = ~bp_o`.
- R4: With the oscillator enabled and at least one annunciator on, every annunciator that is off drives `ann_o[i] = bp_o`.
- R5: When all annunciators are off, every bit of `ann_o` is 0 at all times.
- R6: While `osc_en_i` is low, `bp_o` and `ann_o` are 0 in the same cycle, without waiting for a clock edge. The divider is cleared, so `bp_o` starts low after the next enable.
- R7: A command is a byte `cmd_i` taken on a rising edge with `cmd_valid_i` high. Bits [7:3] must equal 5'b01100. Bits [2:1] give the index `s` (0, 1 or 2 selects `ann_o[0]`, `ann_o[1]` or `ann_o[2]`). Bit [0] = 1 turns annunciator `s` on and 0 turns it off. The new state shows on the outputs after that edge. Any other byte, and any byte taken with `cmd_valid_i` low, changes nothing.
- R8: A command with bits [7:3] = 5'b01100 and index bits [2:1] = 2'b11 changes no annunciator state.
- R9: Commands update the annunciator state while the oscillator is disabled too, and that state appears once the oscillator is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Display timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | Master oscillator enable |
| cmd_valid_i | input | 1 | Command byte strobe |
| cmd_i | input | 8 | Command byte |
| bp_o | output | 1 | Backplane square wave |
| ann_o | output | NUM_ANN | Annunciator frontplanes |

## Verification
The bench builds the block with `CLK_DIV = 8` and the default three annunciators. The short period puts every phase position within a few cycles. That makes it practical to check all eight on/off combinations cycle by cycle over whole periods, and to apply all 256 command bytes from a mixed on/off state, including the unused index 2'b11. Oscillator drops in the middle of a half period are also checked: outputs must go low at once, the waveform must restart low, and commands sent while the oscillator is off must take effect.

// File: rtl/ann_pkg.sv
package ann_pkg;
  localparam logic [4:0] CMD_TAG = 5'b01100;

  typedef struct packed {
    logic       hit;
    logic [1:0] sel;
    logic       val;
  } ann_cmd_t;

  function automatic ann_cmd_t decode_cmd(logic valid, logic [7:0] b);
    ann_cmd_t c;
    c.hit = valid && (b[7:3] == CMD_TAG);
    c.sel = b[2:1];
    c.val = b[0];
    return c;
  endfunction
endpackage

// File: rtl/ann_phase_div.sv
module ann_phase_div #(
  parameter int CLK_DIV = 1280,
  localparam int HALF   = CLK_DIV / 2,
  localparam int CNT_W  = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic             phase_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == CNT_W'(HALF - 1)) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/ann_cmd_dec.sv
module ann_cmd_dec
  import ann_pkg::*;
#(
  parameter int NUM_ANN = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [7:0]         cmd_i,
  output logic [NUM_ANN-1:0] on_o
);
  ann_cmd_t         cmd;
  logic [NUM_ANN-1:0] on_q;

  assign cmd = decode_cmd(cmd_valid_i, cmd_i);

  for (genvar i = 0; i < NUM_ANN; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            on_q[i] <= 1'b0;
      else if (cmd.hit && int'(cmd.sel) == i) on_q[i] <= cmd.val;
    end
  end

  assign on_o = on_q;
endmodule

// File: rtl/ann_fp_mix.sv
module ann_fp_mix #(
  parameter int NUM_ANN = 3
) (
  input  logic               en_i,
  input  logic               phase_i,
  input  logic [NUM_ANN-1:0] on_i,
  output logic               bp_o,
  output logic [NUM_ANN-1:0] fp_o
);
  logic any_on;
  logic bp;

  assign any_on = |on_i;
  assign bp     = en_i & phase_i;
  assign bp_o   = bp;

  // lit segment: antiphase; unlit: in phase; none lit: rest low
  for (genvar i = 0; i < NUM_ANN; i++) begin : g_fp
    assign fp_o[i] = en_i & any_on & (on_i[i] ? ~phase_i : phase_i);
  end
endmodule

// File: rtl/lcd_ann_wave.sv
module lcd_ann_wave #(
  parameter int CLK_DIV = 1280,
  parameter int NUM_ANN = 3,
  localparam int HALF   = CLK_DIV / 2,
  localparam int CNT_W  = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               osc_en_i,
  input  logic               cmd_valid_i,
  input  logic [7:0]         cmd_i,
  output logic               bp_o,
  output logic [NUM_ANN-1:0] ann_o
);
  logic               phase;
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_ANN-1:0] on_q;

  ann_phase_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (osc_en_i),
    .phase_o (phase),
    .cnt_o   (cnt_q)
  );

  ann_cmd_dec #(.NUM_ANN(NUM_ANN)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .on_o        (on_q)
  );

  ann_fp_mix #(.NUM_ANN(NUM_ANN)) u_mix (
    .en_i    (osc_en_i),
    .phase_i (phase),
    .on_i    (on_q),
    .bp_o    (bp_o),
    .fp_o    (ann_o)
  );
endmodule

// File: rtl/ann_wave_chk.sv
module ann_wave_chk #(
  parameter int NUM_ANN = 3,
  parameter int CNT_W   = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               osc_en_i,
  input logic               cmd_valid_i,
  input logic [7:0]         cmd_i,
  input logic               bp_o,
  input logic [NUM_ANN-1:0] ann_o,
  input logic [NUM_ANN-1:0] on_q,
  input logic [CNT_W-1:0]   cnt_q
);
  a_r6_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |-> (!bp_o && ann_o == '0));

  a_r6_restart_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_i) |-> !bp_o);

  a_r2_hold_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_i && $past(osc_en_i) && cnt_q != '0) |-> $stable(bp_o));

  a_r5_none_lit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_q == '0) |-> (ann_o == '0));

  a_r3_r4_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_i && on_q != '0) |-> ((ann_o ^ {NUM_ANN{bp_o}}) == on_q));

  a_r8_sel3_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i[7:3] == 5'b01100 && cmd_i[2:1] == 2'b11) |=> $stable(on_q));

  for (genvar i = 0; i < NUM_ANN; i++) begin : g_set
    a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && cmd_i[7:3] == 5'b01100 && int'(cmd_i[2:1]) == i)
      |=> (on_q[i] == $past(cmd_i[0])));
  end
endmodule

bind lcd_ann_wave ann_wave_chk #(.NUM_ANN(NUM_ANN), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .osc_en_i    (osc_en_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .bp_o        (bp_o),
  .ann_o       (ann_o),
  .on_q        (on_q),
  .cnt_q       (cnt_q)
);

// File: tb/tb_lcd_ann_wave.sv
module tb_lcd_ann_wave;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;
  localparam int NA   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          osc = 1'b0;
  logic          cmd_v = 1'b0;
  logic [7:0]    cmd = 8'h00;
  logic          bp;
  logic [NA-1:0] ann;

  int            checks = 0;
  int            fails  = 0;
  int            n      = 0;
  logic [NA-1:0] on_m   = '0;

  lcd_ann_wave #(.CLK_DIV(DIV), .NUM_ANN(NA)) dut (
    .clk_i(clk), .rst_ni(rst_n), .osc_en_i(osc),
    .cmd_valid_i(cmd_v), .cmd_i(cmd), .bp_o(bp), .ann_o(ann)
  );

  always #5 clk = ~clk;

  task automatic check(string tag);
    logic exp_bp;
    logic exp_a;
    string t;
    exp_bp = osc && (n >= HALF);
    checks++;
    t = (tag != "") ? tag : (osc ? "R2" : "R6");
    if (bp !== exp_bp) begin
      fails++;
      $display("FAIL %s bp actual=%b expected=%b n=%0d", t, bp, exp_bp, n);
    end
    for (int i = 0; i < NA; i++) begin
      exp_a = (osc && on_m != '0) ? (on_m[i] ? ~exp_bp : exp_bp) : 1'b0;
      if (tag != "")       t = tag;
      else if (!osc)       t = "R6";
      else if (on_m == '0) t = "R5";
      else if (on_m[i])    t = "R3";
      else                 t = "R4";
      checks++;
      if (ann[i] !== exp_a) begin
        fails++;
        $display("FAIL %s ann[%0d] actual=%b expected=%b mask=%b", t, i, ann[i], exp_a, on_m);
      end
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    if (rst_n) begin
      n = osc ? (n + 1) % DIV : 0;
      if (cmd_v && cmd[7:3] == 5'b01100 && int'(cmd[2:1]) < NA) on_m[cmd[2:1]] = cmd[0];
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic send(logic [7:0] b, string tag);
    cmd_v = 1'b1;
    cmd   = b;
    step(tag);
    cmd_v = 1'b0;
  endtask

  task automatic set_mask(logic [NA-1:0] m);
    for (int i = 0; i < NA; i++) send(8'b0110_0000 | 8'(i << 1) | 8'(m[i]), "R7");
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1");
    step("R1");
    rst_n = 1'b1;
    step("R1");
    osc = 1'b1;
    // R5 and R2: two full periods with nothing lit
    for (int c = 0; c < 2 * DIV; c++) step("");

    // R3 R4 R5: every on/off combination over a whole period
    for (int m = 0; m < (1 << NA); m++) begin
      set_mask(NA'(m));
      for (int c = 0; c < DIV + 1; c++) step("");
    end

    // R7 R8: all 256 bytes from a mixed state
    for (int b = 0; b < 256; b++) begin
      set_mask(3'b010);
      send(8'(b), (b[7:3] == 5'b01100 && b[2:1] == 2'b11) ? "R8" : "R7");
      step("");
    end
    // R7: strobe low ignored
    set_mask(3'b010);
    cmd = 8'b0110_0001;
    step("R7");
    step("R7");

    // R6: drop oscillator mid half-period, outputs fall without a clock edge
    set_mask(3'b011);
    while (n != HALF + 1) step("");
    osc = 1'b0;
    #1 check("R6");
    for (int c = 0; c < 3; c++) step("R6");
    // R9: command while oscillator is off
    send(8'b0110_0101, "R9");
    osc = 1'b1;
    #1 check("R6");
    for (int c = 0; c < DIV + 2; c++) step("");

    // R1: reset mid-run clears all annunciators
    rst_n = 1'b0;
    n = 0;
    on_m = '0;
    #1 check("R1");
    step("R1");
    rst_n = 1'b1;
    for (int c = 0; c < DIV; c++) step("");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule